// File: doc/BRIEF.md
# Chip-Select Strobe Timing Controller

This block drives the external strobes for one memory region: chip select, output enable, two byte enables, a transfer-error acknowledge and a cycle-done flag. It runs on a clock at twice the bus rate, so each bus clock spans two fast-clock phases. This lets strobe edges be placed on half-bus-clock boundaries. When an access is accepted, the block latches the request (read or write, user or supervisor, byte lanes, access size) and the region configuration (wait-state count, late output enable, early byte-enable negation, write-only byte enables, supervisor protection, port size). It then plays out one bus cycle of 2×(W+1) phases, where W is the wait-state count.

The request port uses a valid/ready handshake. `req_ready` is high only while no cycle is in progress. An access is accepted on the rising edge where `req_valid` and `req_ready` are both high. A requester facing low `req_ready` must hold its request and configuration stable until acceptance. Configuration changes after acceptance do not affect the cycle in progress.

Two kinds of access are refused instead of run: a user-mode access to a protected region, and an access while the port size holds the reserved code. A refused access lasts one bus clock, with no strobes and with the error acknowledge low.

Top module: `csst_ctrl`

## Requirements
- R1: While reset is low and after it is released, `cs_n`, `oe_n`, `eb_n[1:0]` and `tea_n` are high, `done` is low and `req_ready` is high.
- R2: A request is accepted on a rising edge with `req_valid` and `req_ready` both high. `req_ready` stays low from the next phase to the end of the access. The request and configuration are sampled only at acceptance.
- R3: An accepted, non-refused access drives `cs_n` low for exactly 2×(W+1) consecutive phases, starting in the phase after acceptance. Phase 0 is the first of these phases.
- R4: On a read with W>0, `oe_n` is low in every phase of the cycle when the late-OE bit is 0, and in phases 1 through the last when it is 1. `oe_n` is never low on a write.
- R5: With W=0, the late-OE and early-negate bits have no effect. On reads, `oe_n` and any driven byte enable are low in phase 1 only. On writes, byte enables are low in phase 1 only.
- R6: On a write with W>0, driven byte enables are low from phase 1 to the last phase when the early-negate bit is 0, and from phase 1 to the second-to-last phase when it is 1.
- R7: With the write-only bit 0, byte enables on reads follow the `oe_n` window, including its late delay. With it 1, byte enables stay high on reads.
- R8: Port size 2'b00 drives only `eb_n[0]` (upper byte). Port size 2'b01 drives only `eb_n[1]` (lower byte). Port size 2'b10 (16-bit) drives `eb_n[0]` when `req_half` or `req_lane[0]` is set, and `eb_n[1]` when `req_half` or `req_lane[1]` is set.
- R9: A user access (`req_user`=1) to a protected region (`cfg_protect`=1) lasts two phases. During it `cs_n`, `oe_n` and `eb_n` stay high, `tea_n` is low and `done` is high. A supervisor access to the same region runs normally.
- R10: An access with port size 2'b11 is refused in the same way as R9.
- R11: `done` is high for exactly two phases, which are the last bus clock of every completed or refused access, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the bus rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block idle, able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| req_lane | input | 2 | Byte lanes: bit 0 upper, bit 1 lower |
| req_half | input | 1 | 1 = 16-bit access (both lanes) |
| cfg_wsc | input | WSC_W | Wait-state count W |
| cfg_oe_late | input | 1 | Delay OE (and read byte enables) by one phase |
| cfg_eb_early | input | 1 | Negate write byte enables one phase early |
| cfg_eb_wr_only | input | 1 | Byte enables asserted on writes only |
| cfg_protect | input | 1 | Refuse user-mode accesses |
| cfg_port | input | 2 | Port size code |
| cs_n | output | 1 | Chip select, active low |
| oe_n | output | 1 | Output enable, active low |
| eb_n | output | 2 | Byte enables, active low |
| tea_n | output | 1 | Transfer-error acknowledge, active low |
| done | output | 1 | Last bus clock of an access |

## Verification
All strobes come from flops through combinational decode. Phase p of an access is therefore visible in the fast cycle that starts p rising edges after the acceptance edge, and the cycle after the last phase is idle again. The bench drives inputs on falling edges. It samples every output at the falling edge inside each phase, comparing the whole strobe vector against a per-phase model built from the requirements, and it samples once more in the idle phase that follows. Configuration inputs are scrambled right after acceptance in one run, to show they are sampled only at that edge.

// File: rtl/csst_pkg.sv
package csst_pkg;

  typedef enum logic [1:0] {
    PORT_UPPER = 2'b00,
    PORT_LOWER = 2'b01,
    PORT_WIDE  = 2'b10,
    PORT_RSVD  = 2'b11
  } port_e;

  typedef struct packed {
    logic write;
    logic oe_late;
    logic eb_early;
    logic wr_only;
  } mode_t;

  localparam int unsigned LANES = 2;

endpackage

// File: rtl/csst_classify.sv
module csst_classify
  import csst_pkg::*;
(
  input  logic             user,
  input  logic             protect,
  input  logic [1:0]       port,
  input  logic [LANES-1:0] lane,
  input  logic             half,
  output logic             refuse,
  output logic [LANES-1:0] lanes_eff
);

  port_e port_kind;

  always_comb begin
    port_kind = port_e'(port);
    refuse    = (user && protect) || (port_kind == PORT_RSVD);
    unique case (port_kind)
      PORT_UPPER: lanes_eff = 2'b01;
      PORT_LOWER: lanes_eff = 2'b10;
      PORT_WIDE:  lanes_eff = half ? 2'b11 : lane;
      default:    lanes_eff = 2'b00;
    endcase
  end

endmodule

// File: rtl/csst_seq.sv
module csst_seq #(
  parameter int unsigned WSC_W = 4,
  localparam int unsigned PH_W = WSC_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_refuse,
  input  logic [WSC_W-1:0] wsc,
  output logic             busy,
  output logic             refused,
  output logic             zero_ws,
  output logic [PH_W-1:0]  ph,
  output logic [PH_W-1:0]  ph_last
);

  logic            busy_q, refused_q, zero_q;
  logic [PH_W-1:0] ph_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      refused_q <= 1'b0;
      zero_q    <= 1'b0;
      ph_q      <= '0;
      last_q    <= '0;
    end else if (start) begin
      busy_q    <= 1'b1;
      refused_q <= start_refuse;
      zero_q    <= (wsc == '0);
      ph_q      <= '0;
      last_q    <= start_refuse ? PH_W'(1) : {wsc, 1'b1};
    end else if (busy_q) begin
      if (ph_q == last_q) begin
        busy_q    <= 1'b0;
        refused_q <= 1'b0;
        ph_q      <= '0;
      end else begin
        ph_q <= ph_q + PH_W'(1);
      end
    end
  end

  assign busy    = busy_q;
  assign refused = refused_q;
  assign zero_ws = zero_q;
  assign ph      = ph_q;
  assign ph_last = last_q;

endmodule

// File: rtl/csst_window.sv
module csst_window
  import csst_pkg::*;
#(
  parameter int unsigned PH_W = 5
) (
  input  logic             busy,
  input  logic             refused,
  input  logic             zero_ws,
  input  logic [PH_W-1:0]  ph,
  input  logic [PH_W-1:0]  ph_last,
  input  mode_t            mode,
  input  logic [LANES-1:0] lanes,
  output logic             cs_n,
  output logic             oe_n,
  output logic [LANES-1:0] eb_n,
  output logic             tea_n,
  output logic             done
);

  logic live, rd_win, wr_win, eb_act;

  always_comb begin
    live = busy && !refused;
    if (zero_ws) begin
      rd_win = (ph == PH_W'(1));
      wr_win = (ph == PH_W'(1));
    end else begin
      rd_win = mode.oe_late ? (ph != '0) : 1'b1;
      wr_win = (ph != '0) && (!mode.eb_early || (ph != ph_last));
    end
    eb_act = mode.write ? wr_win : (!mode.wr_only && rd_win);
    cs_n   = !live;
    oe_n   = !(live && !mode.write && rd_win);
    tea_n  = !(busy && refused);
    done   = busy && (ph >= ph_last - PH_W'(1));
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign eb_n[g] = !(live && eb_act && lanes[g]);
  end

endmodule

// File: rtl/csst_ctrl.sv
module csst_ctrl
  import csst_pkg::*;
#(
  parameter int unsigned WSC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic             req_user,
  input  logic [1:0]       req_lane,
  input  logic             req_half,
  input  logic [WSC_W-1:0] cfg_wsc,
  input  logic             cfg_oe_late,
  input  logic             cfg_eb_early,
  input  logic             cfg_eb_wr_only,
  input  logic             cfg_protect,
  input  logic [1:0]       cfg_port,
  output logic             cs_n,
  output logic             oe_n,
  output logic [1:0]       eb_n,
  output logic             tea_n,
  output logic             done
);

  localparam int unsigned PH_W = WSC_W + 1;

  logic             start, refuse, busy, refused, zero_ws;
  logic [LANES-1:0] lanes_eff, lanes_q;
  logic [PH_W-1:0]  ph, ph_last;
  mode_t            mode_q;

  assign req_ready = !busy;
  assign start     = req_valid && req_ready;

  csst_classify u_classify (
    .user      (req_user),
    .protect   (cfg_protect),
    .port      (cfg_port),
    .lane      (req_lane),
    .half      (req_half),
    .refuse    (refuse),
    .lanes_eff (lanes_eff)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      lanes_q <= '0;
    end else if (start) begin
      mode_q  <= '{write: req_write, oe_late: cfg_oe_late,
                   eb_early: cfg_eb_early, wr_only: cfg_eb_wr_only};
      lanes_q <= lanes_eff;
    end
  end

  csst_seq #(.WSC_W(WSC_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .start_refuse (refuse),
    .wsc          (cfg_wsc),
    .busy         (busy),
    .refused      (refused),
    .zero_ws      (zero_ws),
    .ph           (ph),
    .ph_last      (ph_last)
  );

  csst_window #(.PH_W(PH_W)) u_window (
    .busy    (busy),
    .refused (refused),
    .zero_ws (zero_ws),
    .ph      (ph),
    .ph_last (ph_last),
    .mode    (mode_q),
    .lanes   (lanes_q),
    .cs_n    (cs_n),
    .oe_n    (oe_n),
    .eb_n    (eb_n),
    .tea_n   (tea_n),
    .done    (done)
  );

endmodule

// File: rtl/csst_ctrl_chk.sv
module csst_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       cs_n,
  input logic       oe_n,
  input logic [1:0] eb_n,
  input logic       tea_n,
  input logic       done
);

  // R2
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n || !tea_n) |-> !req_ready);

  // R2
  accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!cs_n || !tea_n));

  // R4
  oe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !cs_n);

  // R8
  eb_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eb_n != 2'b11) |-> !cs_n);

  // R9
  refuse_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tea_n |-> (cs_n && oe_n && eb_n == 2'b11 && done));

  // R11
  done_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |=> done);

  // R11
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |=> !done);

endmodule

bind csst_ctrl csst_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .cs_n      (cs_n),
  .oe_n      (oe_n),
  .eb_n      (eb_n),
  .tea_n     (tea_n),
  .done      (done)
);

// File: tb/csst_ctrl_tb.sv
module csst_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0, req_half = 1'b0;
  logic [1:0] req_lane = 2'b00, cfg_port = 2'b10;
  logic [3:0] cfg_wsc = 4'd0;
  logic       cfg_oe_late = 1'b0, cfg_eb_early = 1'b0, cfg_eb_wr_only = 1'b0, cfg_protect = 1'b0;
  logic       req_ready, cs_n, oe_n, tea_n, done;
  logic [1:0] eb_n;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  csst_ctrl #(.WSC_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_user(req_user), .req_lane(req_lane), .req_half(req_half),
    .cfg_wsc(cfg_wsc), .cfg_oe_late(cfg_oe_late), .cfg_eb_early(cfg_eb_early),
    .cfg_eb_wr_only(cfg_eb_wr_only), .cfg_protect(cfg_protect), .cfg_port(cfg_port),
    .cs_n(cs_n), .oe_n(oe_n), .eb_n(eb_n), .tea_n(tea_n), .done(done)
  );

  // vector: [14]write [13]user [12:11]lane [10]half [9:6]wsc [5]late [4]early [3]wr_only [2]protect [1:0]port
  localparam int NV = 15;
  localparam logic [14:0] VEC [NV] = '{
    15'b0_0_11_1_0011_0_0_0_0_10,
    15'b0_0_11_1_0011_1_0_0_0_10,
    15'b1_0_11_1_0010_0_0_0_0_10,
    15'b1_0_11_1_0010_0_1_0_0_10,
    15'b0_0_11_1_0000_1_0_0_0_10,
    15'b1_0_11_1_0000_0_1_0_0_10,
    15'b0_0_11_1_0001_0_0_1_0_10,
    15'b1_0_10_0_0001_0_0_0_0_00,
    15'b0_0_01_0_0001_0_0_0_0_01,
    15'b1_0_01_0_0001_0_0_0_0_10,
    15'b0_1_11_1_0011_0_0_0_1_10,
    15'b0_0_11_1_0001_0_0_0_1_10,
    15'b1_1_10_0_0001_0_0_0_0_10,
    15'b1_0_11_1_0010_0_0_0_0_11,
    15'b0_0_11_1_1111_1_1_0_0_10
  };

  function automatic bit refused_of(input logic [14:0] v);
    return (v[13] && v[2]) || (v[1:0] == 2'b11);
  endfunction

  function automatic int len_of(input logic [14:0] v);
    return refused_of(v) ? 2 : 2 * (int'(v[9:6]) + 1);
  endfunction

  // expected {cs_n, oe_n, eb_n[1:0], tea_n, done} in phase p
  function automatic logic [5:0] model(input logic [14:0] v, input int p);
    int  n;
    bit  rd, wr, act;
    logic [1:0] ln;
    n = len_of(v);
    if (refused_of(v)) return 6'b1_1_11_0_1;
    if (v[9:6] == 4'd0) begin
      rd = (p == 1);
      wr = (p == 1);
    end else begin
      rd = v[5] ? (p >= 1) : 1'b1;
      wr = (p >= 1) && (v[4] ? (p <= n - 2) : 1'b1);
    end
    case (v[1:0])
      2'b00:   ln = 2'b01;
      2'b01:   ln = 2'b10;
      default: ln = v[10] ? 2'b11 : v[12:11];
    endcase
    act = v[14] ? wr : (!v[3] && rd);
    return {1'b0, !(!v[14] && rd), ~(act ? ln : 2'b00), 1'b1, (p >= n - 2)};
  endfunction

  function automatic string tag_of(input logic [14:0] v);
    if (v[13] && v[2])                  return "R9";
    if (v[1:0] == 2'b11)                return "R10";
    if (v[9:6] == 4'd0)                 return "R5";
    if (v[1:0] != 2'b10 || !v[10])      return "R8";
    if (v[3])                           return "R7";
    if (v[14])                          return "R6";
    return "R4";
  endfunction

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_vec(input logic [14:0] v, input bit scramble);
    int n, nd;
    n = len_of(v);
    nd = 0;
    @(negedge clk);
    {req_write, req_user, req_lane, req_half, cfg_wsc, cfg_oe_late,
     cfg_eb_early, cfg_eb_wr_only, cfg_protect, cfg_port} = v;
    req_valid = 1'b1;
    check("R2", {5'b0, req_ready}, 6'b000001);
    @(negedge clk);
    req_valid = 1'b0;
    if (scramble) begin
      cfg_wsc = ~cfg_wsc; cfg_oe_late = ~cfg_oe_late; cfg_eb_early = ~cfg_eb_early;
      cfg_eb_wr_only = ~cfg_eb_wr_only; cfg_port = 2'b11; req_write = ~req_write;
    end
    for (int p = 0; p < n; p++) begin
      if (p > 0) @(negedge clk);
      check(scramble ? "R2" : tag_of(v), {cs_n, oe_n, eb_n, tea_n, done}, model(v, p));
      if (p == 0) check("R2", {5'b0, req_ready}, 6'b0);
      if (done) nd++;
    end
    check("R11", 6'(nd), 6'd2);
    @(negedge clk);
    check("R3", {cs_n, oe_n, eb_n, tea_n, done, req_ready}[6:1], 6'b1_1_11_1_0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1", {cs_n, oe_n, eb_n, tea_n, done}, 6'b1_1_11_1_0);
    check("R1", {5'b0, req_ready}, 6'b000001);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", {cs_n, oe_n, eb_n, tea_n, done}, 6'b1_1_11_1_0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], 1'b0);

    // R2: configuration changed after acceptance has no effect
    run_vec(15'b0_0_11_1_0010_0_0_0_0_10, 1'b1);
    // R3: longest cycle back to back with a short one
    run_vec(15'b1_0_11_1_1111_0_1_0_0_10, 1'b0);
    run_vec(15'b0_0_10_0_0000_0_0_0_0_10, 1'b0);

    // R1: reset in the middle of an access returns to idle
    @(negedge clk);
    {req_write, req_user, req_lane, req_half, cfg_wsc, cfg_oe_late,
     cfg_eb_early, cfg_eb_wr_only, cfg_protect, cfg_port} = 15'b0_0_11_1_0100_0_0_0_0_10;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", {cs_n, oe_n, eb_n, tea_n, done}, 6'b1_1_11_1_0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {5'b0, req_ready}, 6'b000001);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule